// File: doc/BRIEF.md
# Way Sharing Utilization Evaluator

This block sits beside a shared last-level cache that is split into private per-core partitions by way. Over a repartitioning period it is fed a stream of stack-distance observations. Each one says that a given core touched a given monitored set at a given LRU stack position. For every core, stack position and monitored set it keeps one sticky used bit. The utilization of a stack position is the number of distinct monitored sets whose bit is set.

When asked to evaluate, the block takes each core's private way count from the partition sizing logic. It then walks that core's allocated ways from the least recently used end toward the most recently used end. Each way whose stack position is touched by fewer sets than a sharing threshold moves to the shared partition. The walk of a core stops at the first way that is used heavily enough. The block returns new private counts and a shared count whose total equals the private total it was given. It then clears its used bits so the next period starts fresh.

Top module: `way_share_eval`

## Requirements
- R1: After reset, `done` is 0, every private count on `priv_out` is 0 and `shared_out` is 0.
- R2: A record with `rec_valid` high while idle marks core `rec_core`, set `rec_set`, position `rec_pos` as used. Position 0 is MRU and NWAYS-1 is LRU. Repeated records of the same set add nothing to that position's utilization.
- R3: A way is moved to the shared partition only when its utilization is strictly less than `thresh`. A utilization equal to `thresh` keeps the way private.
- R4: For a core with private count P, the ways examined are stack positions P-1 down to 0, in that order. Examination of that core ends at the first position that is not underutilized, even if lower positions are underutilized.
- R5: Each core is judged only on its own used bits.
- R6: After an evaluation, the sum of all private counts on `priv_out` plus `shared_out` equals the sum of the private counts on `priv_in`. This sum is stable throughout the evaluation.
- R7: All used bits are cleared on the cycle that completes an evaluation. A following evaluation with no new records sees zero utilization everywhere.
- R8: `done` is a one-cycle pulse. It rises on the (S+NCORES)-th clock edge after the edge that accepts `start`, where S is the number of ways moved to sharing.
- R9: `start` is ignored while an evaluation is in progress. Outputs hold their values between evaluations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Stack-distance record strobe |
| rec_core | input | CIW | Core of the record |
| rec_set | input | $clog2(NSETS) | Monitored set index |
| rec_pos | input | $clog2(NWAYS) | LRU stack position, 0 = MRU |
| start | input | 1 | Begin an evaluation |
| thresh | input | $clog2(NSETS+1) | Sharing threshold in sets |
| priv_in | input | NCORES*WW | Private way counts, core c at bits [c*WW +: WW] |
| priv_out | output | NCORES*WW | Resulting private way counts, same packing |
| shared_out | output | WW | Resulting shared way count |
| done | output | 1 | Evaluation complete pulse |

## Verification
Several usage patterns are tried. In one, a light tail sits at the LRU end below heavy positions, which shows how far the walk proceeds before it stops. In another, heavy LRU positions sit above light MRU positions, which shows that the walk stops early and does not skip ahead. Empty cores show that all ways are released, and a threshold of zero shows that none are. Utilization exactly at the threshold separates a strict comparison from a non-strict one. Repeated records of one set separate counting distinct sets from counting hits. A back-to-back evaluation with no new records shows that the used bits were cleared, and the measured latency pins down the one-way-per-cycle walk.

// File: rtl/way_share_eval.sv
module way_share_eval #(
  parameter int NCORES = 2,
  parameter int NWAYS  = 16,
  parameter int NSETS  = 32,
  localparam int CIW = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int SIW = $clog2(NSETS),
  localparam int PIW = $clog2(NWAYS),
  localparam int UW  = $clog2(NSETS + 1),
  localparam int WW  = $clog2(NWAYS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rec_valid,
  input  logic [CIW-1:0]       rec_core,
  input  logic [SIW-1:0]       rec_set,
  input  logic [PIW-1:0]       rec_pos,
  input  logic                 start,
  input  logic [UW-1:0]        thresh,
  input  logic [NCORES*WW-1:0] priv_in,
  output logic [NCORES*WW-1:0] priv_out,
  output logic [WW-1:0]        shared_out,
  output logic                 done
);

  logic [NSETS-1:0] used [NCORES*NWAYS];
  logic [WW-1:0]    priv_r [NCORES];
  logic [WW-1:0]    shared_r;
  logic [CIW-1:0]   cur;
  logic             busy;

  logic [WW-1:0]    cur_cnt;
  logic [PIW-1:0]   cur_pos;
  logic [UW-1:0]    util;
  logic             share_ok;
  logic             last_core;
  int               rd_idx;

  assign cur_cnt   = priv_r[cur];
  assign cur_pos   = PIW'(cur_cnt - WW'(1));
  assign last_core = (int'(cur) == NCORES - 1);

  always_comb begin
    rd_idx   = int'(cur) * NWAYS + int'(cur_pos);
    util     = UW'($countones(used[rd_idx]));
    share_ok = (cur_cnt != '0) && (util < thresh);
  end

  for (genvar c = 0; c < NCORES; c++) begin : g_out
    assign priv_out[c*WW +: WW] = priv_r[c];
  end
  assign shared_out = shared_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cur      <= '0;
      shared_r <= '0;
      for (int c = 0; c < NCORES; c++) priv_r[c] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          cur      <= '0;
          shared_r <= '0;
          for (int c = 0; c < NCORES; c++) priv_r[c] <= priv_in[c*WW +: WW];
        end
      end else if (share_ok) begin
        priv_r[cur] <= cur_cnt - WW'(1);
        shared_r    <= shared_r + WW'(1);
      end else if (last_core) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cur <= cur + CIW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (busy && !share_ok && last_core)) begin
      for (int i = 0; i < NCORES*NWAYS; i++) used[i] <= '0;
    end else if (rec_valid && !busy) begin
      used[int'(rec_core) * NWAYS + int'(rec_pos)][rec_set] <= 1'b1;
    end
  end

endmodule

// File: rtl/way_share_eval_chk.sv
module way_share_eval_chk #(
  parameter int NCORES = 2,
  parameter int NWAYS  = 16,
  localparam int WW = $clog2(NWAYS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 done,
  input logic [NCORES*WW-1:0] priv_out,
  input logic [WW-1:0]        shared_out
);

  function automatic int total(input logic [NCORES*WW-1:0] p, input logic [WW-1:0] s);
    int t = int'(s);
    for (int c = 0; c < NCORES; c++) t += int'(p[c*WW +: WW]);
    return t;
  endfunction

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_sum_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> total(priv_out, shared_out) == $past(total(priv_out, shared_out)));

  p_shared_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> shared_out >= $past(shared_out));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(priv_out) && $stable(shared_out)));

endmodule

bind way_share_eval way_share_eval_chk #(.NCORES(NCORES), .NWAYS(NWAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .priv_out(priv_out), .shared_out(shared_out)
);

// File: tb/tb_way_share_eval.sv
`timescale 1ns/1ps
module tb_way_share_eval;
  localparam int NCORES = 2;
  localparam int NWAYS  = 16;
  localparam int NSETS  = 32;
  localparam int WW     = $clog2(NWAYS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rec_valid = 1'b0;
  logic [0:0] rec_core = '0;
  logic [4:0] rec_set = '0;
  logic [3:0] rec_pos = '0;
  logic start = 1'b0;
  logic [5:0] thresh = '0;
  logic [NCORES*WW-1:0] priv_in = '0;
  logic [NCORES*WW-1:0] priv_out;
  logic [WW-1:0] shared_out;
  logic done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int lat;

  always #2.5 clk = ~clk;

  way_share_eval #(.NCORES(NCORES), .NWAYS(NWAYS), .NSETS(NSETS)) dut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_core(rec_core),
    .rec_set(rec_set), .rec_pos(rec_pos), .start(start), .thresh(thresh),
    .priv_in(priv_in), .priv_out(priv_out), .shared_out(shared_out), .done(done)
  );

  // p0 p1 thr lo0 hi0 sp0 lo1 hi1 sp1 ; util(pos) = pos>=sp ? lo : hi
  localparam logic [71:0] VEC [0:5] = '{
    {8'd8,  8'd8,  8'd4,  8'd2,  8'd10, 8'd5, 8'd0, 8'd10, 8'd6},
    {8'd10, 8'd6,  8'd3,  8'd3,  8'd20, 8'd2, 8'd1, 8'd5,  8'd0},
    {8'd4,  8'd12, 8'd1,  8'd0,  8'd0,  8'd0, 8'd0, 8'd0,  8'd0},
    {8'd12, 8'd4,  8'd32, 8'd31, 8'd32, 8'd8, 8'd32, 8'd2, 8'd3},
    {8'd9,  8'd7,  8'd0,  8'd0,  8'd0,  8'd0, 8'd0, 8'd0,  8'd0},
    {8'd7,  8'd9,  8'd5,  8'd20, 8'd1,  8'd3, 8'd1, 8'd9,  8'd8}
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired: actual=%0d expected<=150000 cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rec(input int c, input int s, input int p);
    @(negedge clk);
    rec_valid = 1'b1; rec_core = 1'(c); rec_set = 5'(s); rec_pos = 4'(p);
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic load_core(input int c, input int lo, input int hi, input int sp);
    for (int p = 0; p < NWAYS; p++) begin
      for (int s = 0; s < ((p >= sp) ? lo : hi); s++) rec(c, s, p);
    end
  endtask

  function automatic int keep(input int pc, input int thr, input int lo, input int hi, input int sp);
    int k = pc;
    while (k > 0) begin
      if ((((k - 1) >= sp) ? lo : hi) < thr) k--;
      else break;
    end
    return k;
  endfunction

  task automatic run(input int p0, input int p1, input int thr, input int hold);
    @(negedge clk);
    priv_in = {WW'(p1), WW'(p0)};
    thresh = 6'(thr);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lat = 1;
    if (hold == 0) start = 1'b0;
    while (!done && lat < 200) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done", int'(done), 0);
    check("R1 priv", int'(priv_out), 0);
    check("R1 shared", int'(shared_out), 0);
    rst_n = 1'b1;

    for (int v = 0; v < 6; v++) begin
      int p0, p1, thr, k0, k1, sh;
      p0 = int'(VEC[v][71:64]); p1 = int'(VEC[v][63:56]); thr = int'(VEC[v][55:48]);
      load_core(0, int'(VEC[v][47:40]), int'(VEC[v][39:32]), int'(VEC[v][31:24]));
      load_core(1, int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]));
      k0 = keep(p0, thr, int'(VEC[v][47:40]), int'(VEC[v][39:32]), int'(VEC[v][31:24]));
      k1 = keep(p1, thr, int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]));
      sh = (p0 - k0) + (p1 - k1);
      run(p0, p1, thr, (v == 5) ? 1 : 0);  // v5 holds start while busy: R9
      check("R3 R4 R5 core0 private", int'(priv_out[WW-1:0]), k0);
      check("R3 R4 R5 core1 private", int'(priv_out[2*WW-1:WW]), k1);
      check("R6 shared", int'(shared_out), sh);
      check("R8 R9 latency", lat, sh + NCORES + 1);
      @(negedge clk);
      check("R8 done one cycle", int'(done), 0);
    end

    // R2: ten hits on one set count as one used set
    for (int p = 0; p < NWAYS - 1; p++) begin
      for (int s = 0; s < NSETS; s++) rec(0, s, p);
    end
    for (int i = 0; i < 10; i++) rec(0, 7, NWAYS - 1);
    run(16, 0, 2, 0);
    check("R2 repeat set shared", int'(shared_out), 1);
    check("R2 repeat set private", int'(priv_out[WW-1:0]), 15);

    // R2/R3: two distinct sets equal threshold 2 stay private
    rec(0, 3, NWAYS - 1);
    rec(0, 9, NWAYS - 1);
    run(16, 0, 2, 0);
    check("R2 R3 two sets kept", int'(shared_out), 0);

    // R7: bits cleared by previous evaluation
    run(16, 0, 1, 0);
    check("R7 cleared all shared", int'(shared_out), 16);
    check("R7 cleared private", int'(priv_out[WW-1:0]), 0);

    // R9: outputs hold while idle
    repeat (5) @(negedge clk);
    check("R9 hold shared", int'(shared_out), 16);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule